// File: doc/BRIEF.md
# SPI Master Transmit/Receive Word Buffers

This block holds the data words that travel between a bus-side host and the shift engine of an SPI master. The transmit side queues words that the host pushes and hands them to the shift engine through a valid/ready load handshake. The receive side stores words that the shift engine delivers and lets the host pop them in arrival order. Each side is a small first-in-first-out queue.

Either queue can be put into bypass mode. In bypass mode the queue accepts only one word, so together with the external shift register it behaves as a plain double buffer. A small control port sets the two bypass bits and issues one-cycle flush strobes. The bypass bits follow a lock rule: they can be written only while the module-disable input is low. Sticky error flags report a push that was refused, a pop that was refused and a receive word that was dropped.

Top module: `spi_buf_top`

## Requirements
- R1: With TX bypass on (control bit 0 = 1), the TX queue holds at most one word. A push to that held word is refused, `tx_count_o` stays 1, `tx_full_o` is 1 and the held word is still presented on `tx_load_data_o`.
- R2: With RX bypass on (control bit 1 = 1), the RX queue holds at most one word. A second arriving word is dropped, the first stays on `rx_data_o` and `rx_count_o` stays 1.
- R3: A control write updates bits 0 and 1 only when `mdis_i` is 0. While `mdis_i` is 1 the write leaves them unchanged. `cfg_rdata_o` bits 0 and 1 return them.
- R4: With bypass off, each queue starts empty after reset, holds up to 4 words of 16 bits and returns them in the order they were written. A TX word leaves on a cycle with `tx_load_valid_o` and `tx_load_ready_i` both high.
- R5: A control write with bit 2 = 1 empties the TX queue by the next cycle and clears `tx_push_err_o`. This works whatever the value of `mdis_i`.
- R6: A control write with bit 3 = 1 empties the RX queue by the next cycle and clears `rx_pop_err_o` and `rx_ovf_o`. This works whatever the value of `mdis_i`.
- R7: Control bits 2 and 3 are strobes and always read back as 0 on `cfg_rdata_o`.
- R8: A push to a full TX queue is refused. The queue content is unchanged and `tx_push_err_o` is set and held.
- R9: A pop from an empty RX queue is refused and sets and holds `rx_pop_err_o`.
- R10: When a TX flush and a push happen in the same cycle, the flush wins: the pushed word is dropped and `tx_count_o` is 0 afterwards.
- R11: A word that arrives from the shift engine while the RX queue is full is dropped without changing the stored words, and `rx_ovf_o` is set and held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdis_i | input | 1 | Module disable; while high, bypass bits are locked |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_wdata_i | input | 4 | Control write data: bit0 TX bypass, bit1 RX bypass, bit2 TX flush, bit3 RX flush |
| cfg_rdata_o | output | 4 | Control read data (flush bits read 0) |
| tx_push_i | input | 1 | Host pushes a TX word |
| tx_data_i | input | 16 | TX word to push |
| tx_full_o | output | 1 | TX queue at capacity |
| tx_count_o | output | 3 | Words held in TX queue |
| tx_load_valid_o | output | 1 | A TX word is available to the shift engine |
| tx_load_data_o | output | 16 | Oldest TX word |
| tx_load_ready_i | input | 1 | Shift engine takes the TX word |
| rx_store_valid_i | input | 1 | Shift engine delivers an RX word |
| rx_store_data_i | input | 16 | Delivered RX word |
| rx_pop_i | input | 1 | Host pops an RX word |
| rx_data_o | output | 16 | Oldest RX word |
| rx_empty_o | output | 1 | RX queue empty |
| rx_count_o | output | 3 | Words held in RX queue |
| tx_push_err_o | output | 1 | Sticky: a TX push was refused |
| rx_pop_err_o | output | 1 | Sticky: an RX pop was refused |
| rx_ovf_o | output | 1 | Sticky: an RX word was dropped because the queue was full |

## Verification
The bench pushes a fifth word into a full TX queue. A design that wrapped its pointer there would overwrite the oldest word or corrupt the count. It pops an empty RX queue, where a broken design would underflow the count and report stale data. It issues a flush in the same cycle as a push, which would leave one word behind if the push were allowed to win. It writes the bypass bits while the module is disabled, where a missing lock would change the buffer capacity. It also fills each queue in bypass mode, where a design that ignored bypass would accept a second word instead of flagging it.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int unsigned CFG_W       = 4;
  localparam int unsigned CFG_TX_BYP  = 0;
  localparam int unsigned CFG_RX_BYP  = 1;
  localparam int unsigned CFG_TX_CLR  = 2;
  localparam int unsigned CFG_RX_CLR  = 3;

  typedef struct packed {
    logic rx_byp;
    logic tx_byp;
  } buf_cfg_t;
endpackage

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
  import spi_buf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mdis_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output buf_cfg_t         cfg_o,
  output logic             tx_clr_o,
  output logic             rx_clr_o
);
  buf_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !mdis_i) begin
      cfg_q.tx_byp <= wdata_i[CFG_TX_BYP];
      cfg_q.rx_byp <= wdata_i[CFG_RX_BYP];
    end
  end

  // flush strobes are not subject to the lock
  assign tx_clr_o = we_i & wdata_i[CFG_TX_CLR];
  assign rx_clr_o = we_i & wdata_i[CFG_RX_CLR];
  assign cfg_o    = cfg_q;

  always_comb begin
    rdata_o             = '0;
    rdata_o[CFG_TX_BYP] = cfg_q.tx_byp;
    rdata_o[CFG_RX_BYP] = cfg_q.rx_byp;
  end

  assert_cfg_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mdis_i) |=> $stable(cfg_q));
endmodule

// File: rtl/spi_buf_sticky.sv
module spi_buf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (clr_i)   flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_sticky_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
endmodule

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bypass_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_BYP  = CW'(1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] cap;

  assign cap       = bypass_i ? CAP_BYP : CAP_FIFO;
  assign full_o    = (count_q >= cap);
  assign empty_o   = (count_q == '0);
  assign push_ok_o = push_i & ~full_o & ~flush_i;
  assign pop_ok_o  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o   = mem_q[rd_ptr_q];
  assign count_o   = count_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CAP_FIFO);
  // flush empties the queue and wins over a push (R5, R6)
  assert_flush_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
  assert_full_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count_q));
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (count_q == '0));
endmodule

// File: rtl/spi_buf_top.sv
module spi_buf_top
  import spi_buf_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mdis_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             tx_full_o,
  output logic [CW-1:0]    tx_count_o,
  output logic             tx_load_valid_o,
  output logic [DW-1:0]    tx_load_data_o,
  input  logic             tx_load_ready_i,
  input  logic             rx_store_valid_i,
  input  logic [DW-1:0]    rx_store_data_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_empty_o,
  output logic [CW-1:0]    rx_count_o,
  output logic             tx_push_err_o,
  output logic             rx_pop_err_o,
  output logic             rx_ovf_o
);
  buf_cfg_t cfg;
  logic tx_clr, rx_clr;
  logic tx_empty, tx_push_ok, tx_pop_ok;
  logic rx_full, rx_push_ok, rx_pop_ok;

  spi_buf_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mdis_i   (mdis_i),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .cfg_o    (cfg),
    .tx_clr_o (tx_clr),
    .rx_clr_o (rx_clr)
  );

  spi_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bypass_i  (cfg.tx_byp),
    .flush_i   (tx_clr),
    .push_i    (tx_push_i),
    .wdata_i   (tx_data_i),
    .pop_i     (tx_load_ready_i),
    .rdata_o   (tx_load_data_o),
    .count_o   (tx_count_o),
    .full_o    (tx_full_o),
    .empty_o   (tx_empty),
    .push_ok_o (tx_push_ok),
    .pop_ok_o  (tx_pop_ok)
  );

  spi_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bypass_i  (cfg.rx_byp),
    .flush_i   (rx_clr),
    .push_i    (rx_store_valid_i),
    .wdata_i   (rx_store_data_i),
    .pop_i     (rx_pop_i),
    .rdata_o   (rx_data_o),
    .count_o   (rx_count_o),
    .full_o    (rx_full),
    .empty_o   (rx_empty_o),
    .push_ok_o (rx_push_ok),
    .pop_ok_o  (rx_pop_ok)
  );

  // no word is offered in a flush cycle, so none is lost to the engine
  assign tx_load_valid_o = ~tx_empty & ~tx_clr;

  spi_buf_sticky u_tx_push_err (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (tx_push_i & tx_full_o), .clr_i (tx_clr), .flag_o (tx_push_err_o)
  );
  spi_buf_sticky u_rx_pop_err (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rx_pop_i & rx_empty_o), .clr_i (rx_clr), .flag_o (rx_pop_err_o)
  );
  spi_buf_sticky u_rx_ovf (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rx_store_valid_i & rx_full), .clr_i (rx_clr), .flag_o (rx_ovf_o)
  );

  assert_tx_byp_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.tx_byp && tx_count_o == CW'(1) && tx_push_i && !tx_load_ready_i && !tx_clr)
      |=> (tx_count_o == CW'(1)) && tx_push_err_o);
  assert_rx_byp_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.rx_byp && rx_count_o == CW'(1) && rx_store_valid_i && !rx_pop_i && !rx_clr)
      |=> (rx_count_o == CW'(1)) && rx_ovf_o);
  assert_rx_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_store_valid_i && rx_full && !rx_pop_i && !rx_clr)
      |=> rx_ovf_o && $stable(rx_count_o) && $stable(rx_data_o));
  assert_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_empty_o && !rx_clr) |=> rx_pop_err_o);
  assert_tx_handshake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_ok && !tx_push_ok) |=> (tx_count_o == $past(tx_count_o) - CW'(1)));
  assert_rx_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_ok && !rx_pop_ok) |=> (rx_count_o == $past(rx_count_o) + CW'(1)));
endmodule

// File: tb/spi_buf_top_tb.sv
module spi_buf_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic mdis, cfg_we, tx_push, tx_ready, rx_valid, rx_pop;
  logic [3:0] cfg_wd, cfg_rd;
  logic [15:0] tx_d, tx_ld, rx_sd, rx_d;
  logic tx_full, tx_lv, rx_empty, tx_perr, rx_perr, rx_ovf;
  logic [2:0] tx_cnt, rx_cnt;

  spi_buf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mdis_i(mdis),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .tx_push_i(tx_push), .tx_data_i(tx_d), .tx_full_o(tx_full), .tx_count_o(tx_cnt),
    .tx_load_valid_o(tx_lv), .tx_load_data_o(tx_ld), .tx_load_ready_i(tx_ready),
    .rx_store_valid_i(rx_valid), .rx_store_data_i(rx_sd), .rx_pop_i(rx_pop),
    .rx_data_o(rx_d), .rx_empty_o(rx_empty), .rx_count_o(rx_cnt),
    .tx_push_err_o(tx_perr), .rx_pop_err_o(rx_perr), .rx_ovf_o(rx_ovf)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        we;
    logic [3:0]  wd;
    logic        push;
    logic [15:0] td;
    logic        ld;
    logic        st;
    logic [15:0] sd;
    logic        pop;
    logic [2:0]  e_txc;
    logic [2:0]  e_rxc;
    logic [15:0] e_txh;
    logic [15:0] e_rxh;
    logic [2:0]  e_err; // {ovf, pop_err, push_err}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 1'b1, 16'hA001, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd1, 3'd0, 16'hA001, 16'h0000, 3'b000},
    '{1'b0, 4'h0, 1'b1, 16'hA002, 1'b0, 1'b1, 16'hB001, 1'b0, 3'd2, 3'd1, 16'hA001, 16'hB001, 3'b000},
    '{1'b0, 4'h0, 1'b1, 16'hA003, 1'b1, 1'b0, 16'h0000, 1'b0, 3'd2, 3'd1, 16'hA002, 16'hB001, 3'b000},
    '{1'b0, 4'h0, 1'b1, 16'hA004, 1'b0, 1'b1, 16'hB002, 1'b0, 3'd3, 3'd2, 16'hA002, 16'hB001, 3'b000},
    '{1'b0, 4'h0, 1'b1, 16'hA005, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd4, 3'd2, 16'hA002, 16'hB001, 3'b000},
    '{1'b0, 4'h0, 1'b1, 16'hA006, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd4, 3'd2, 16'hA002, 16'hB001, 3'b001},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 3'd4, 3'd1, 16'hA002, 16'hB002, 3'b001},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 3'd4, 3'd0, 16'hA002, 16'h0000, 3'b001},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 3'd4, 3'd0, 16'hA002, 16'h0000, 3'b011},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 3'd3, 3'd0, 16'hA003, 16'h0000, 3'b011},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 3'd2, 3'd0, 16'hA004, 16'h0000, 3'b011},
    '{1'b0, 4'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 3'd1, 3'd0, 16'hA005, 16'h0000, 3'b011},
    '{1'b1, 4'h4, 1'b1, 16'hA007, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd0, 3'd0, 16'h0000, 16'h0000, 3'b010},
    '{1'b1, 4'h8, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd0, 3'd0, 16'h0000, 16'h0000, 3'b000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_wd = '0; tx_push = 0; tx_d = '0; tx_ready = 0;
    rx_valid = 0; rx_sd = '0; rx_pop = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic done();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    mdis = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R4)
    chk("R4 reset tx_count", tx_cnt, 0);
    chk("R4 reset rx_count", rx_cnt, 0);
    chk("R4 reset tx_load_valid", tx_lv, 0);
    chk("R4 reset rx_empty", rx_empty, 1);
    chk("R3 reset cfg_rdata", cfg_rd, 0);
    chk("R8 reset errors", {rx_ovf, rx_perr, tx_perr}, 0);

    // vector walk: R4 order/depth, R8 full push, R9 empty pop, R10 flush+push, R5, R6
    for (int i = 0; i < NV; i++) begin
      cfg_we = VECS[i].we; cfg_wd = VECS[i].wd;
      tx_push = VECS[i].push; tx_d = VECS[i].td; tx_ready = VECS[i].ld;
      rx_valid = VECS[i].st; rx_sd = VECS[i].sd; rx_pop = VECS[i].pop;
      step();
      chk($sformatf("R4/R10 vec%0d tx_count", i), tx_cnt, VECS[i].e_txc);
      chk($sformatf("R4/R11 vec%0d rx_count", i), rx_cnt, VECS[i].e_rxc);
      if (VECS[i].e_txc != 0) chk($sformatf("R4 vec%0d tx head", i), tx_ld, VECS[i].e_txh);
      if (VECS[i].e_rxc != 0) chk($sformatf("R4 vec%0d rx head", i), rx_d, VECS[i].e_rxh);
      chk($sformatf("R8/R9/R5/R6 vec%0d errors", i), {rx_ovf, rx_perr, tx_perr}, VECS[i].e_err);
    end

    // R3: lock while disabled
    mdis = 1; cfg_we = 1; cfg_wd = 4'h3; step();
    chk("R3 locked write ignored", cfg_rd, 0);
    mdis = 0; cfg_we = 1; cfg_wd = 4'h3; step();
    chk("R3 unlocked write taken", cfg_rd, 3);
    // R7: strobes read zero
    cfg_we = 1; cfg_wd = 4'hF; step();
    chk("R7 flush bits read 0", cfg_rd, 3);

    // R1: TX bypass single word
    tx_push = 1; tx_d = 16'h1111; step();
    chk("R1 first push held", tx_cnt, 1);
    tx_push = 1; tx_d = 16'h2222; step();
    chk("R1 count stays 1", tx_cnt, 1);
    chk("R1 full", tx_full, 1);
    chk("R1 push err", tx_perr, 1);
    chk("R1 held word", tx_ld, 16'h1111);
    tx_ready = 1; step();
    chk("R1 drained", tx_cnt, 0);
    chk("R1 load valid low", tx_lv, 0);

    // R2: RX bypass single word
    rx_valid = 1; rx_sd = 16'hC001; step();
    rx_valid = 1; rx_sd = 16'hC002; step();
    chk("R2 count stays 1", rx_cnt, 1);
    chk("R2 first word kept", rx_d, 16'hC001);
    chk("R2 overflow flag", rx_ovf, 1);

    // R5/R6: flush clears errors, bypass off
    cfg_we = 1; cfg_wd = 4'hC; step();
    chk("R5 push err cleared", tx_perr, 0);
    chk("R6 ovf cleared", rx_ovf, 0);
    chk("R6 rx emptied", rx_cnt, 0);
    chk("R3 bypass off", cfg_rd, 0);

    // R11: normal mode overflow
    for (int k = 0; k < 4; k++) begin
      rx_valid = 1; rx_sd = 16'hD000 + 16'(k); step();
    end
    chk("R11 filled", rx_cnt, 4);
    chk("R11 no ovf yet", rx_ovf, 0);
    rx_valid = 1; rx_sd = 16'hDEAD; step();
    chk("R11 count unchanged", rx_cnt, 4);
    chk("R11 ovf set", rx_ovf, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R11 stored words intact", rx_d, 16'hD000 + 16'(k));
      rx_pop = 1; step();
    end
    chk("R11 drained", rx_cnt, 0);

    // R6: flush works while disabled
    rx_valid = 1; rx_sd = 16'hE001; step();
    mdis = 1; cfg_we = 1; cfg_wd = 4'h8; step();
    chk("R6 flush under mdis", rx_cnt, 0);
    chk("R6 ovf cleared under mdis", rx_ovf, 0);
    mdis = 0;

    done();
  end
endmodule